// File: doc/BRIEF.md
# Sector Buffer Address Sequencer

This block drives the address and strobe lines of an on-board sector RAM that a host bus port and a local processor/formatter port both reach. It turns a qualified access request into a registered RAM chip-enable with separate write-enables for the two sources. It also keeps the buffer address, which advances by one each time an access completes. An access completes when chip-enable falls, and a write is committed on that same trailing edge.

The address runs in two ways at once. A sector counter wraps the address at a programmable sector size and pulses an end-of-sector flag. A short-transfer counter serves transfers of eight bytes or fewer. Software clears it, presets it with dummy accesses and then arms it. The counter then pulses a done flag when the real accesses bring it to its terminal count. With K dummy accesses, exactly 8 - K real accesses follow before done.

Top module: `sbuf_addr_seq`

## Requirements
- R1: While reset is held and after its release, with no request, ram_ce, ram_we_host, ram_we_local, wr_commit, short_done, sec_end are 0 and ram_addr is 0.
- R2: A request is qualified when (cpu_req or seq_req) is 1, bsel is 1 and a10 is 0. ram_ce equals the qualification sampled at the previous clock edge. An unqualified request leaves ram_ce at 0 and does not move ram_addr.
- R3: ram_we_host is 1 only while ram_ce is 1 and host_wr was sampled with the request. ram_we_local behaves the same way for cpu_wr. A read access raises neither.
- R4: ram_addr advances by exactly one in the cycle after ram_ce falls and holds at all other times. wr_commit pulses for one cycle in that same cycle only when the completed access was a write.
- R5: cnt_clr sets ram_addr to 0, zeroes the short count and disarms the short counter, so no done follows until a new arm.
- R6: After cnt_clr, K dummy accesses (K from 0 to 7) and a short_arm pulse, short_done pulses for one cycle after exactly N = 8 - K real accesses. The required N values 1, 3, 4, 6 and 8 are included, and no done occurs during the dummy accesses.
- R7: short_done is raised once per arm. Further accesses after it do not raise it again.
- R8: size_load with size_sel = s (0 to 3) selects a sector of 128 << s bytes and zeroes ram_addr. The access completed at address size-1 returns ram_addr to 0 and pulses sec_end for one cycle.
- R9: sec_end repeats at the end of each successive sector and stays 0 for every other access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor/formatter RAM request |
| seq_req | input | 1 | Sequencer RAM request |
| bsel | input | 1 | Board select qualifier |
| a10 | input | 1 | Address bit 10; request is qualified only when 0 |
| host_wr | input | 1 | Access is a host bus write |
| cpu_wr | input | 1 | Access is a processor/formatter write |
| cnt_clr | input | 1 | Clear address and short counter |
| short_arm | input | 1 | Arm short-transfer done detection |
| size_load | input | 1 | Load sector size and clear address |
| size_sel | input | 2 | Sector size code, 128 << size_sel bytes |
| ram_ce | output | 1 | RAM chip-enable |
| ram_we_host | output | 1 | RAM write-enable for host bus access |
| ram_we_local | output | 1 | RAM write-enable for processor/formatter access |
| ram_addr | output | 10 | RAM byte address |
| wr_commit | output | 1 | One-cycle write commit at chip-enable trailing edge |
| short_done | output | 1 | One-cycle short-transfer done pulse |
| sec_end | output | 1 | One-cycle end-of-sector pulse |

## Verification
The bench builds the block with its default parameters: a 10-bit address, a short-transfer limit of 8 and a 128-byte minimum sector. At these values every sector size can be walked to completion, and the two 128-byte sectors test the wrap more than once. Every dummy preset count from 0 to 7 is swept, which covers each short length from 8 down to 1, including the required lengths. Expected addresses, wraps and done positions come from plain arithmetic on the access count.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
    localparam int SZ_SEL_W = 2;

    typedef enum logic [SZ_SEL_W-1:0] {
        SEC_128  = 2'd0,
        SEC_256  = 2'd1,
        SEC_512  = 2'd2,
        SEC_1024 = 2'd3
    } sec_size_e;
endpackage

// File: rtl/sbuf_strobe.sv
module sbuf_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic seq_req,
    input  logic bsel,
    input  logic a10,
    input  logic host_wr,
    input  logic cpu_wr,
    output logic ce,
    output logic we_host,
    output logic we_local,
    output logic acc_done,
    output logic wr_commit
);
    typedef struct packed {
        logic ce;
        logic weh;
        logic wel;
        logic cmt;
    } stb_t;

    stb_t q, d;
    logic req;

    always_comb begin
        req   = (cpu_req | seq_req) & bsel & ~a10;
        d.ce  = req;
        d.weh = req & host_wr;
        d.wel = req & cpu_wr;
        // trailing edge of chip-enable completes the access
        d.cmt = q.ce & ~req & (q.weh | q.wel);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ce        = q.ce;
    assign we_host   = q.weh;
    assign we_local  = q.wel;
    assign acc_done  = q.ce & ~req;
    assign wr_commit = q.cmt;
endmodule

// File: rtl/sbuf_addr_ctr.sv
module sbuf_addr_ctr
    import sbuf_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int SZ_MIN_LOG = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc,
    input  logic                cnt_clr,
    input  logic                size_load,
    input  logic [SZ_SEL_W-1:0] size_sel,
    output logic [ADDR_W-1:0]   addr,
    output logic                sec_end
);
    localparam int SHMAX = ADDR_W - SZ_MIN_LOG;
    localparam logic [ADDR_W-1:0] ALL1 = '1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        sec_size_e         sz;
        logic              sec;
    } ac_t;

    ac_t q, d;
    logic [ADDR_W-1:0] last;

    always_comb begin
        last  = ALL1 >> (SHMAX - int'(q.sz));
        d     = q;
        d.sec = 1'b0;
        if (size_load) begin
            d.sz   = sec_size_e'(size_sel);
            d.addr = '0;
        end else if (cnt_clr) begin
            d.addr = '0;
        end else if (acc) begin
            if (q.addr == last) begin
                d.addr = '0;
                d.sec  = 1'b1;
            end else begin
                d.addr = q.addr + ADDR_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{addr: '0, sz: SEC_128, sec: 1'b0};
        else        q <= d;
    end

    assign addr    = q.addr;
    assign sec_end = q.sec;
endmodule

// File: rtl/sbuf_short_ctr.sv
module sbuf_short_ctr #(
    parameter int SHORT_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc,
    input  logic cnt_clr,
    input  logic arm,
    output logic done
);
    localparam int SC_W = $clog2(SHORT_MAX + 1);

    typedef struct packed {
        logic [SC_W-1:0] cnt;
        logic            armed;
        logic            done;
    } sc_t;

    sc_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (cnt_clr) begin
            d.cnt   = '0;
            d.armed = 1'b0;
        end else begin
            if (arm) d.armed = 1'b1;
            if (acc) begin
                if (q.cnt != SC_W'(SHORT_MAX)) d.cnt = q.cnt + SC_W'(1);
                if (q.armed && q.cnt == SC_W'(SHORT_MAX - 1)) begin
                    d.done  = 1'b1;
                    d.armed = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = q.done;
endmodule

// File: rtl/sbuf_addr_seq.sv
module sbuf_addr_seq
    import sbuf_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int SZ_MIN_LOG = 7,
    parameter int SHORT_MAX  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              seq_req,
    input  logic              bsel,
    input  logic              a10,
    input  logic              host_wr,
    input  logic              cpu_wr,
    input  logic              cnt_clr,
    input  logic              short_arm,
    input  logic              size_load,
    input  logic [1:0]        size_sel,
    output logic              ram_ce,
    output logic              ram_we_host,
    output logic              ram_we_local,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              wr_commit,
    output logic              short_done,
    output logic              sec_end
);
    logic acc;

    sbuf_strobe u_stb (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .seq_req   (seq_req),
        .bsel      (bsel),
        .a10       (a10),
        .host_wr   (host_wr),
        .cpu_wr    (cpu_wr),
        .ce        (ram_ce),
        .we_host   (ram_we_host),
        .we_local  (ram_we_local),
        .acc_done  (acc),
        .wr_commit (wr_commit)
    );

    sbuf_addr_ctr #(.ADDR_W(ADDR_W), .SZ_MIN_LOG(SZ_MIN_LOG)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .cnt_clr   (cnt_clr),
        .size_load (size_load),
        .size_sel  (size_sel),
        .addr      (ram_addr),
        .sec_end   (sec_end)
    );

    sbuf_short_ctr #(.SHORT_MAX(SHORT_MAX)) u_short (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (acc),
        .cnt_clr (cnt_clr),
        .arm     (short_arm),
        .done    (short_done)
    );
endmodule

// File: rtl/sbuf_addr_seq_chk.sv
module sbuf_addr_seq_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_clr,
    input logic              size_load,
    input logic              ram_ce,
    input logic              ram_we_host,
    input logic              ram_we_local,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              wr_commit,
    input logic              short_done,
    input logic              sec_end
);
    logic pv;
    always_ff @(posedge clk) begin
        if (!rst_n) pv <= 1'b0;
        else        pv <= 1'b1;
    end

    // R3
    we_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we_host || ram_we_local) |-> ram_ce);

    // R4
    commit_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && wr_commit) |-> ($past(ram_we_host || ram_we_local) && !ram_ce));

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && ram_addr != $past(ram_addr)) |->
            (($past(ram_ce) && !ram_ce) || $past(cnt_clr) || $past(size_load)));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        short_done |=> !short_done);

    // R6
    done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && short_done) |-> ($past(ram_ce) && !ram_ce));

    // R8
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_end |-> (ram_addr == '0));
endmodule

bind sbuf_addr_seq sbuf_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_clr      (cnt_clr),
    .size_load    (size_load),
    .ram_ce       (ram_ce),
    .ram_we_host  (ram_we_host),
    .ram_we_local (ram_we_local),
    .ram_addr     (ram_addr),
    .wr_commit    (wr_commit),
    .short_done   (short_done),
    .sec_end      (sec_end)
);

// File: tb/sbuf_addr_seq_bench.sv
module sbuf_addr_seq_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 0, seq_req = 0, bsel = 0, a10 = 0, host_wr = 0, cpu_wr = 0;
    logic cnt_clr = 0, short_arm = 0, size_load = 0;
    logic [1:0] size_sel = 0;
    logic ram_ce, ram_we_host, ram_we_local, wr_commit, short_done, sec_end;
    logic [9:0] ram_addr;

    int checks = 0, errors = 0;
    int exp_addr = 0, exp_size = 128;
    logic s_ce, s_weh, s_wel, s_cmt, s_done, s_sec;
    int s_addr;
    bit finished = 0;

    always #2 clk = ~clk;

    sbuf_addr_seq u_sbuf_addr_seq (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .seq_req(seq_req),
        .bsel(bsel), .a10(a10), .host_wr(host_wr), .cpu_wr(cpu_wr),
        .cnt_clr(cnt_clr), .short_arm(short_arm), .size_load(size_load),
        .size_sel(size_sel), .ram_ce(ram_ce), .ram_we_host(ram_we_host),
        .ram_we_local(ram_we_local), .ram_addr(ram_addr), .wr_commit(wr_commit),
        .short_done(short_done), .sec_end(sec_end)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic access(input bit wr, input bit host, input bit use_seq);
        @(negedge clk);
        cpu_req = !use_seq; seq_req = use_seq; bsel = 1; a10 = 0;
        host_wr = wr & host; cpu_wr = wr & !host;
        @(negedge clk);
        s_ce = ram_ce; s_weh = ram_we_host; s_wel = ram_we_local;
        cpu_req = 0; seq_req = 0; host_wr = 0; cpu_wr = 0;
        @(negedge clk);
        s_addr = int'(ram_addr); s_cmt = wr_commit; s_done = short_done; s_sec = sec_end;
        if (exp_addr == exp_size - 1) exp_addr = 0;
        else exp_addr = exp_addr + 1;
    endtask

    task automatic pulse_clr();
        @(negedge clk); cnt_clr = 1;
        @(negedge clk); cnt_clr = 0;
        exp_addr = 0;
    endtask

    task automatic pulse_arm();
        @(negedge clk); short_arm = 1;
        @(negedge clk); short_arm = 0;
    endtask

    task automatic load_size(input int sel);
        @(negedge clk); size_sel = 2'(sel); size_load = 1;
        @(negedge clk); size_load = 0;
        exp_addr = 0; exp_size = 128 << sel;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk(ram_ce == 0 && ram_we_host == 0 && ram_we_local == 0, "R1 strobes", int'(ram_ce), 0);
        chk(wr_commit == 0 && short_done == 0 && sec_end == 0, "R1 pulses", int'(short_done), 0);
        chk(ram_addr == 0, "R1 addr", int'(ram_addr), 0);
        rst_n = 1;
        @(negedge clk);
        chk(ram_ce == 0 && ram_addr == 0, "R1 after release", int'(ram_addr), 0);

        // R2: unqualified requests
        cpu_req = 1; bsel = 0; a10 = 0;
        @(negedge clk);
        chk(ram_ce == 0, "R2 bsel low", int'(ram_ce), 0);
        bsel = 1; a10 = 1;
        @(negedge clk);
        chk(ram_ce == 0, "R2 a10 high", int'(ram_ce), 0);
        cpu_req = 0; a10 = 0; bsel = 0;
        @(negedge clk); @(negedge clk);
        chk(ram_addr == 0, "R2 no advance", int'(ram_addr), 0);

        // R2 R3 R4: sequencer read
        access(0, 0, 1);
        chk(s_ce == 1, "R2 seq qualified", int'(s_ce), 1);
        chk(s_weh == 0 && s_wel == 0, "R3 read no we", int'(s_weh) + int'(s_wel), 0);
        chk(s_cmt == 0, "R4 read no commit", int'(s_cmt), 0);
        chk(s_addr == exp_addr, "R4 addr step", s_addr, exp_addr);
        // R3 R4: host write
        access(1, 1, 0);
        chk(s_weh == 1 && s_wel == 0, "R3 host we", int'(s_weh), 1);
        chk(s_cmt == 1, "R4 host commit", int'(s_cmt), 1);
        chk(s_addr == exp_addr, "R4 addr step", s_addr, exp_addr);
        // R3 R4: local write
        access(1, 0, 0);
        chk(s_wel == 1 && s_weh == 0, "R3 local we", int'(s_wel), 1);
        chk(s_cmt == 1, "R4 local commit", int'(s_cmt), 1);
        chk(s_addr == exp_addr, "R4 addr step", s_addr, exp_addr);
        @(negedge clk);
        chk(wr_commit == 0 && ram_addr == 10'(exp_addr), "R4 hold", int'(ram_addr), exp_addr);

        // R5: clear
        pulse_clr();
        chk(ram_addr == 0, "R5 clear addr", int'(ram_addr), 0);

        // R6 R7: every preset count
        for (int k = 0; k < 8; k++) begin
            pulse_clr();
            for (int i = 0; i < k; i++) begin
                access(i[0], 0, 0);
                chk(s_done == 0, "R6 no done on dummy", int'(s_done), 0);
            end
            pulse_arm();
            for (int i = 1; i <= 8 - k; i++) begin
                access(0, 0, i[0]);
                chk(s_done == (i == 8 - k), "R6 done position", int'(s_done), int'(i == 8 - k));
                chk(s_addr == exp_addr, "R4 short addr", s_addr, exp_addr);
            end
            access(1, 1, 0);
            chk(s_done == 0, "R7 no second done", int'(s_done), 0);
        end

        // R5: clear after arm disarms
        pulse_clr();
        for (int i = 0; i < 4; i++) access(0, 0, 0);
        pulse_arm();
        access(0, 0, 0);
        pulse_clr();
        chk(ram_addr == 0, "R5 clear mid", int'(ram_addr), 0);
        for (int i = 0; i < 8; i++) begin
            access(0, 0, 0);
            chk(s_done == 0, "R5 disarmed", int'(s_done), 0);
        end

        // R8 R9: every sector size
        for (int sel = 0; sel < 4; sel++) begin
            load_size(sel);
            chk(ram_addr == 0, "R8 load clears", int'(ram_addr), 0);
            for (int n = 1; n <= (sel == 0 ? 2 : 1) * (128 << sel); n++) begin
                access(n[1], n[2], n[0]);
                chk(s_sec == ((n % (128 << sel)) == 0), "R9 sec_end position",
                    int'(s_sec), int'((n % (128 << sel)) == 0));
                chk(s_addr == exp_addr, "R8 addr wrap", s_addr, exp_addr);
            end
        end

        summary();
    end
endmodule